// File: doc/BRIEF.md
# Synchronous Exception Trap-Entry Unit

This block performs the trap entry for one synchronous exception of a RISC-V style core. When the core raises the exception-valid strobe, the block turns the exception kind into an architectural cause code. It then decides, from the current privilege and the per-cause delegation mask, whether supervisor or machine mode handles the trap. One clock later it presents everything the core needs to commit the entry: a PC load with the handler address, the new privilege, and a write strobe for the target mode's trap registers. The strobe comes with data for the exception PC, cause, trap value and status.

The status value written back is a read-modify-write of the supplied status word. Only the interrupt-enable stack and the previous-privilege field of the target mode change. Every entry also reports a classification (fatal, invisible or requested), so the surrounding environment knows how the trap is meant to end. A reserved current privilege, or an exception kind with no defined cause, raises an error pulse and commits nothing.

Top module: `trap_entry_unit`

## Requirements
- R1: Kind to cause mapping (4-bit kind → cause code): 0 illegal→2, 1 breakpoint→3, 2 ecall-U→8, 3 ecall-S→9, 4 ecall-M→11, 5 fetch misaligned→0, 6 fetch access→1, 7 fetch page→12, 8 load misaligned→4, 9 load access→5, 10 load page→13, 11 store misaligned→6, 12 store access→7, 13 store page→15. The cause appears on `cause_wdata`.
- R2: The trap is delegated to supervisor (`sup_wr`=1, `mode_q`=2'b01) only when the current privilege is User (2'b00) or Supervisor (2'b01) and bit `cause` of the low 16 bits of `medeleg` is 1. Otherwise it goes to machine (`mach_wr`=1, `mode_q`=2'b11).
- R3: `epc_wdata` equals `cur_pc` minus 4, modulo 2^XLEN, with bit 0 cleared.
- R4: `pc_next` equals the target mode's vector (`stvec` or `mtvec`) with bit 0 cleared, and `tval_wdata` is zero.
- R5: On supervisor entry the status output has bit 5 set to the input bit 1, bit 1 cleared, and bit 8 set to 0 when coming from User and to 1 otherwise.
- R6: On machine entry the status output has bit 7 set to the input bit 3, bit 3 cleared, and bits 12:11 set to the previous privilege (00 User, 01 Supervisor, 11 Machine).
- R7: `trap_class` is 2'b00 (fatal) for misaligned and access faults, 2'b01 (invisible) for illegal instruction and page faults, and 2'b10 (requested) for breakpoint and environment calls.
- R8: A valid strobe with current privilege 2'b10 pulses `bad_mode` for one cycle. It raises no write strobe or PC load, and `mode_q` is unchanged.
- R9: Kinds 14 and 15 have no cause. They pulse `bad_cause` for one cycle, are never delegated, and commit no state.
- R10: After reset, `mode_q` is Machine (2'b11), all strobes and error flags are 0, and `trap_class` is 2'b11. `pc_load`, `mode_q`, and exactly one of `sup_wr`/`mach_wr` update in the cycle after an accepted strobe, and the strobes last exactly one cycle.
- R11: With `exc_valid` low, no strobe or error flag is raised and `mode_q` holds.
- R12: All status bits other than those named in R5/R6 pass through from `status_in` to `status_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Exception request strobe |
| exc_kind | input | 4 | Exception kind (R1 encoding) |
| cur_pc | input | XLEN | Current program counter |
| cur_mode | input | 2 | Current privilege |
| medeleg | input | XLEN | Exception delegation mask |
| stvec | input | XLEN | Supervisor trap vector |
| mtvec | input | XLEN | Machine trap vector |
| status_in | input | XLEN | Present status word |
| pc_load | output | 1 | Load `pc_next` into the PC |
| pc_next | output | XLEN | Handler address |
| mode_q | output | 2 | Privilege after entry |
| sup_wr | output | 1 | Write supervisor trap registers |
| mach_wr | output | 1 | Write machine trap registers |
| epc_wdata | output | XLEN | Exception PC data |
| cause_wdata | output | XLEN | Cause data |
| tval_wdata | output | XLEN | Trap value data |
| status_wdata | output | XLEN | New status word |
| trap_class | output | 2 | Classification of the last trap |
| bad_mode | output | 1 | Reserved-privilege error pulse |
| bad_cause | output | 1 | Undefined-kind error pulse |

## Verification
The bench sweeps all sixteen kinds against all four privilege encodings and three delegation masks. The masks are all clear, all set, and a mixed pattern that delegates some causes and not others. Together they separate the privilege gate from the mask lookup and check each cause's bit index. The PC values include zero, to check the wrap, and odd addresses, to check the bit-0 clear. The status words vary per trial, so pass-through bits and both enable-stack directions are seen with ones and zeros. An idle cycle after every trial checks that the strobes drop and that the privilege holds.

// File: rtl/trap_pkg.sv
package trap_pkg;

   typedef enum logic [1:0] {
      PRV_U    = 2'b00,
      PRV_S    = 2'b01,
      PRV_RSVD = 2'b10,
      PRV_M    = 2'b11
   } priv_e;

   typedef enum logic [1:0] {
      TC_FATAL     = 2'b00,
      TC_INVISIBLE = 2'b01,
      TC_REQUESTED = 2'b10,
      TC_NONE      = 2'b11
   } tclass_e;

   localparam int unsigned CAUSE_W = 5;

endpackage

// File: rtl/trap_cause_map.sv
module trap_cause_map
   import trap_pkg::*;
#(
   parameter int unsigned KIND_W = 4
) (
   input  logic [KIND_W-1:0]  kind,
   output logic [CAUSE_W-1:0] cause,
   output tclass_e            cls,
   output logic               known
);

   generate
      if (KIND_W < 4) begin : g_bad_kind_w
         $error("trap_cause_map: KIND_W must cover 14 kinds");
      end
   endgenerate

   always_comb begin
      known = 1'b1;
      cause = '0;
      cls   = TC_NONE;
      case (kind)
         KIND_W'(0):  begin cause = 5'd2;  cls = TC_INVISIBLE; end
         KIND_W'(1):  begin cause = 5'd3;  cls = TC_REQUESTED; end
         KIND_W'(2):  begin cause = 5'd8;  cls = TC_REQUESTED; end
         KIND_W'(3):  begin cause = 5'd9;  cls = TC_REQUESTED; end
         KIND_W'(4):  begin cause = 5'd11; cls = TC_REQUESTED; end
         KIND_W'(5):  begin cause = 5'd0;  cls = TC_FATAL;     end
         KIND_W'(6):  begin cause = 5'd1;  cls = TC_FATAL;     end
         KIND_W'(7):  begin cause = 5'd12; cls = TC_INVISIBLE; end
         KIND_W'(8):  begin cause = 5'd4;  cls = TC_FATAL;     end
         KIND_W'(9):  begin cause = 5'd5;  cls = TC_FATAL;     end
         KIND_W'(10): begin cause = 5'd13; cls = TC_INVISIBLE; end
         KIND_W'(11): begin cause = 5'd6;  cls = TC_FATAL;     end
         KIND_W'(12): begin cause = 5'd7;  cls = TC_FATAL;     end
         KIND_W'(13): begin cause = 5'd15; cls = TC_INVISIBLE; end
         default:     begin known = 1'b0;                      end
      endcase
   end

endmodule

// File: rtl/trap_route.sv
module trap_route
   import trap_pkg::*;
#(
   parameter int unsigned DELEG_W = 16
) (
   input  priv_e              from_mode,
   input  logic [DELEG_W-1:0] deleg_mask,
   input  logic [CAUSE_W-1:0] cause,
   input  logic               known,
   output logic               to_sup
);

   generate
      if (DELEG_W < 16) begin : g_bad_deleg_w
         $error("trap_route: DELEG_W must reach cause 15");
      end
   endgenerate

   logic [DELEG_W-1:0] shifted;
   logic               low_priv;

   always_comb begin
      shifted  = deleg_mask >> cause;
      low_priv = (from_mode == PRV_U) || (from_mode == PRV_S);
      to_sup   = known && low_priv && shifted[0];
   end

endmodule

// File: rtl/trap_status_upd.sv
module trap_status_upd
   import trap_pkg::*;
#(
   parameter int unsigned XLEN   = 32,
   parameter bit          TO_SUP = 1'b0
) (
   input  logic [XLEN-1:0] status_in,
   input  priv_e           from_mode,
   output logic [XLEN-1:0] status_out
);

   generate
      if (XLEN < 13) begin : g_bad_xlen
         $error("trap_status_upd: XLEN too narrow for status fields");
      end

      if (TO_SUP) begin : g_sup
         localparam int unsigned IE_B  = 1;
         localparam int unsigned PIE_B = 5;
         localparam int unsigned PP_B  = 8;
         always_comb begin
            status_out        = status_in;
            status_out[PIE_B] = status_in[IE_B];
            status_out[IE_B]  = 1'b0;
            status_out[PP_B]  = (from_mode != PRV_U);
         end
      end else begin : g_mach
         localparam int unsigned IE_B  = 3;
         localparam int unsigned PIE_B = 7;
         localparam int unsigned PP_LO = 11;
         always_comb begin
            status_out                  = status_in;
            status_out[PIE_B]           = status_in[IE_B];
            status_out[IE_B]            = 1'b0;
            status_out[PP_LO+1:PP_LO]   = from_mode;
         end
      end
   endgenerate

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
   import trap_pkg::*;
#(
   parameter int unsigned XLEN     = 32,
   parameter int unsigned KIND_W   = 4,
   parameter int unsigned DELEG_W  = 16,
   parameter int unsigned PC_STEP  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exc_valid,
   input  logic [KIND_W-1:0] exc_kind,
   input  logic [XLEN-1:0]   cur_pc,
   input  logic [1:0]        cur_mode,
   input  logic [XLEN-1:0]   medeleg,
   input  logic [XLEN-1:0]   stvec,
   input  logic [XLEN-1:0]   mtvec,
   input  logic [XLEN-1:0]   status_in,
   output logic              pc_load,
   output logic [XLEN-1:0]   pc_next,
   output logic [1:0]        mode_q,
   output logic              sup_wr,
   output logic              mach_wr,
   output logic [XLEN-1:0]   epc_wdata,
   output logic [XLEN-1:0]   cause_wdata,
   output logic [XLEN-1:0]   tval_wdata,
   output logic [XLEN-1:0]   status_wdata,
   output logic [1:0]        trap_class,
   output logic              bad_mode,
   output logic              bad_cause
);

   localparam logic [XLEN-1:0] STEP_V   = XLEN'(PC_STEP);
   localparam logic [XLEN-1:0] LSB_MASK = ~XLEN'(1);

   generate
      if (DELEG_W > XLEN) begin : g_bad_deleg
         $error("trap_entry_unit: DELEG_W exceeds XLEN");
      end
      if (PC_STEP == 0) begin : g_bad_step
         $error("trap_entry_unit: PC_STEP must be nonzero");
      end
   endgenerate

   priv_e              from_mode;
   logic [CAUSE_W-1:0] cause;
   tclass_e            cls;
   logic               known;
   logic               to_sup;
   logic               mode_ok;
   logic               accept;
   logic [XLEN-1:0]    st_sup;
   logic [XLEN-1:0]    st_mach;

   assign from_mode = priv_e'(cur_mode);
   assign mode_ok   = (from_mode != PRV_RSVD);
   assign accept    = exc_valid && mode_ok && known;

   trap_cause_map #(.KIND_W(KIND_W)) u_map (
      .kind  (exc_kind),
      .cause (cause),
      .cls   (cls),
      .known (known)
   );

   trap_route #(.DELEG_W(DELEG_W)) u_route (
      .from_mode  (from_mode),
      .deleg_mask (medeleg[DELEG_W-1:0]),
      .cause      (cause),
      .known      (known),
      .to_sup     (to_sup)
   );

   trap_status_upd #(.XLEN(XLEN), .TO_SUP(1'b1)) u_st_sup (
      .status_in  (status_in),
      .from_mode  (from_mode),
      .status_out (st_sup)
   );

   trap_status_upd #(.XLEN(XLEN), .TO_SUP(1'b0)) u_st_mach (
      .status_in  (status_in),
      .from_mode  (from_mode),
      .status_out (st_mach)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_load      <= 1'b0;
         pc_next      <= '0;
         mode_q       <= PRV_M;
         sup_wr       <= 1'b0;
         mach_wr      <= 1'b0;
         epc_wdata    <= '0;
         cause_wdata  <= '0;
         tval_wdata   <= '0;
         status_wdata <= '0;
         trap_class   <= TC_NONE;
         bad_mode     <= 1'b0;
         bad_cause    <= 1'b0;
      end else begin
         pc_load   <= accept;
         sup_wr    <= accept && to_sup;
         mach_wr   <= accept && !to_sup;
         bad_mode  <= exc_valid && !mode_ok;
         bad_cause <= exc_valid && !known;
         if (accept) begin
            mode_q       <= to_sup ? PRV_S : PRV_M;
            pc_next      <= (to_sup ? stvec : mtvec) & LSB_MASK;
            epc_wdata    <= (cur_pc - STEP_V) & LSB_MASK;
            cause_wdata  <= XLEN'(cause);
            tval_wdata   <= '0;
            status_wdata <= to_sup ? st_sup : st_mach;
            trap_class   <= cls;
         end
      end
   end

   assert_take_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_valid && cur_mode != 2'b10 && exc_kind < KIND_W'(14)) |=> (pc_load && $onehot0({sup_wr, mach_wr}) && (sup_wr || mach_wr)));

   assert_pulse_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_load && !$past(exc_valid)) |-> 1'b0);

   assert_rsvd_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_valid && cur_mode == 2'b10) |=> (!pc_load && !sup_wr && !mach_wr && bad_mode && $stable(mode_q)));

   assert_no_deleg_bad_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_valid && exc_kind >= KIND_W'(14)) |=> (!sup_wr && !pc_load && bad_cause));

   assert_sup_from_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sup_wr |-> ($past(cur_mode) == 2'b00 || $past(cur_mode) == 2'b01));

   assert_mode_tracks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |-> ((sup_wr && mode_q == 2'b01) || (mach_wr && mode_q == 2'b11)));

   assert_vec_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |-> (!pc_next[0] && !epc_wdata[0] && tval_wdata == '0));

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_valid |=> (!pc_load && !bad_mode && !bad_cause && $stable(mode_q)));

endmodule

// File: tb/tb_trap_entry_unit.sv
module tb_trap_entry_unit;

   localparam int XLEN = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            exc_valid = 1'b0;
   logic [3:0]      exc_kind = '0;
   logic [XLEN-1:0] cur_pc = '0;
   logic [1:0]      cur_mode = 2'b11;
   logic [XLEN-1:0] medeleg = '0;
   logic [XLEN-1:0] stvec = '0;
   logic [XLEN-1:0] mtvec = '0;
   logic [XLEN-1:0] status_in = '0;
   logic            pc_load;
   logic [XLEN-1:0] pc_next;
   logic [1:0]      mode_q;
   logic            sup_wr;
   logic            mach_wr;
   logic [XLEN-1:0] epc_wdata;
   logic [XLEN-1:0] cause_wdata;
   logic [XLEN-1:0] tval_wdata;
   logic [XLEN-1:0] status_wdata;
   logic [1:0]      trap_class;
   logic            bad_mode;
   logic            bad_cause;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   trap_entry_unit dut (
      .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_kind(exc_kind),
      .cur_pc(cur_pc), .cur_mode(cur_mode), .medeleg(medeleg), .stvec(stvec),
      .mtvec(mtvec), .status_in(status_in), .pc_load(pc_load), .pc_next(pc_next),
      .mode_q(mode_q), .sup_wr(sup_wr), .mach_wr(mach_wr), .epc_wdata(epc_wdata),
      .cause_wdata(cause_wdata), .tval_wdata(tval_wdata), .status_wdata(status_wdata),
      .trap_class(trap_class), .bad_mode(bad_mode), .bad_cause(bad_cause)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int cause_of(input int k);
      case (k)
         0: return 2;   1: return 3;   2: return 8;   3: return 9;
         4: return 11;  5: return 0;   6: return 1;   7: return 12;
         8: return 4;   9: return 5;   10: return 13; 11: return 6;
         12: return 7;  13: return 15; default: return -1;
      endcase
   endfunction

   function automatic logic [1:0] class_of(input int k);
      if (k == 0 || k == 7 || k == 10 || k == 13) return 2'b01;
      if (k >= 1 && k <= 4) return 2'b10;
      return 2'b00;
   endfunction

   initial begin
      int wd = 0;
      while (!done && wd < 20000) begin
         @(posedge clk);
         wd++;
      end
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [1:0] exp_mode;
      logic [XLEN-1:0] masks [3];
      masks[0] = 32'h0000_0000;
      masks[1] = 32'hFFFF_FFFF;
      masks[2] = 32'h0000_B36D;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(mode_q == 2'b11, "R10 reset mode", mode_q, 2'b11);
      chk(!pc_load && !sup_wr && !mach_wr, "R10 reset strobes", {pc_load, sup_wr, mach_wr}, 0);
      chk(!bad_mode && !bad_cause, "R10 reset errors", {bad_mode, bad_cause}, 0);
      chk(trap_class == 2'b11, "R10 reset class", trap_class, 2'b11);
      exp_mode = 2'b11;

      for (int m = 0; m < 4; m++) begin
         for (int d = 0; d < 3; d++) begin
            for (int k = 0; k < 16; k++) begin
               int c;
               int t;
               bit known;
               bit acc;
               bit dl;
               logic [XLEN-1:0] pcv;
               logic [XLEN-1:0] st;
               logic [XLEN-1:0] est;
               logic [XLEN-1:0] eepc;
               t = m * 48 + d * 16 + k;
               c = cause_of(k);
               known = (c >= 0);
               acc = known && (m != 2);
               dl = acc && (m <= 1) && masks[d][c & 15];
               pcv = (t % 7 == 0) ? 32'h0 : (32'h1000_0001 + 32'(t) * 32'h104);
               st = 32'hA5C3_5A3C ^ (32'(t) * 32'h9E37_79B9);
               eepc = (pcv - 32'd4) & ~32'd1;
               est = st;
               if (dl) begin
                  est[5] = st[1]; est[1] = 1'b0; est[8] = (m != 0);
               end else begin
                  est[7] = st[3]; est[3] = 1'b0; est[12:11] = 2'(m);
               end

               exc_valid = 1'b1;
               exc_kind  = 4'(k);
               cur_mode  = 2'(m);
               cur_pc    = pcv;
               medeleg   = masks[d];
               stvec     = 32'h8000_1001 + 32'(d) * 32'h40;
               mtvec     = 32'h8000_2003 + 32'(t);
               status_in = st;
               @(negedge clk);

               if (acc) begin
                  exp_mode = dl ? 2'b01 : 2'b11;
                  chk(pc_load, "R10 pc_load", pc_load, 1);
                  chk(sup_wr == dl && mach_wr == !dl, "R2 target", {sup_wr, mach_wr}, {dl, !dl});
                  chk(mode_q == exp_mode, "R2 mode", mode_q, exp_mode);
                  chk(cause_wdata == 32'(c), "R1 cause", cause_wdata, c);
                  chk(epc_wdata == eepc, "R3 epc", epc_wdata, eepc);
                  chk(pc_next == ((dl ? stvec : mtvec) & ~32'd1), "R4 vector", pc_next, (dl ? stvec : mtvec) & ~32'd1);
                  chk(tval_wdata == 0, "R4 tval", tval_wdata, 0);
                  // R5 / R6 / R12: full status word compare
                  chk(status_wdata == est, dl ? "R5 status" : "R6 status", status_wdata, est);
                  chk(trap_class == class_of(k), "R7 class", trap_class, class_of(k));
               end else begin
                  chk(!pc_load && !sup_wr && !mach_wr, known ? "R8 no commit" : "R9 no commit", {pc_load, sup_wr, mach_wr}, 0);
                  chk(mode_q == exp_mode, known ? "R8 mode held" : "R9 mode held", mode_q, exp_mode);
                  chk(bad_mode == (m == 2), "R8 bad_mode", bad_mode, m == 2);
                  chk(bad_cause == !known, "R9 bad_cause", bad_cause, !known);
               end

               exc_valid = 1'b0;
               @(negedge clk);
               chk(!pc_load && !sup_wr && !mach_wr, "R11 idle strobes", {pc_load, sup_wr, mach_wr}, 0);
               chk(!bad_mode && !bad_cause, "R11 idle errors", {bad_mode, bad_cause}, 0);
               chk(mode_q == exp_mode, "R11 idle mode", mode_q, exp_mode);
            end
         end
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule